// File: doc/BRIEF.md
# Rotate-and-Mask Word Execution Unit

This unit executes the two 32-bit rotate-left-then-mask instructions of a big-endian-numbered RISC integer pipeline. Each issue supplies an instruction word, the value already read for the source operand, and the value of the shift operand. The unit decodes the M-form fields and picks the rotate amount by primary opcode: the immediate form takes it from the instruction, the register form from the low five bits of the shift operand. The low word of the source is rotated left, ANDed with a mask that runs from a begin index to an end index (wrapping when begin exceeds end), and zero-extended to 64 bits.

The result, the destination index and the write enables come out of one register stage, one clock after issue. When the record flag is set, a 4-bit condition field is also produced from a signed compare of the 32-bit result against zero, with the summary-overflow bit copied from the incoming XER[SO]. Words with any other primary opcode produce no writes. Register file access, fetch and the insert form are handled elsewhere.

Top module: `rotmask_unit`

## Requirements
- R1: Fields are taken from `instr` with bit 31 as the MSB: primary opcode `instr[31:26]`, destination index `instr[20:16]`, immediate rotate amount `instr[15:11]`, mask begin `instr[10:6]`, mask end `instr[5:1]`, record flag `instr[0]`; `dst_idx` carries the destination index of the issued word.
- R2: With opcode 23 the rotate amount is `rb_val[4:0]`; all higher bits of `rb_val` have no effect on the result.
- R3: With opcode 21 the rotate amount is the immediate field and `rb_val` has no effect on the result.
- R4: When begin ≤ end, the mask has every bit i set with begin ≤ i ≤ end, where i = 0 names result bit 31; begin = end gives exactly one set bit.
- R5: When begin > end, the mask covers i = begin through 31 and i = 0 through end.
- R6: `result[63:32]` is always zero, and `rs_val[63:32]` has no effect on the result.
- R7: With a legal opcode and the record flag set, `cr_we` is 1 and `cr0` is {LT, GT, EQ, SO} in bits 3..0: exactly one of LT (result bit 31 set), GT (nonzero, bit 31 clear) or EQ (zero) is 1, and SO equals `xer_so` at issue.
- R8: With the record flag clear, `cr_we` is 0 while `gpr_we` is 1 for a legal opcode.
- R9: When `issue_vld` is 0, or the opcode is neither 21 nor 23, both `gpr_we` and `cr_we` are 0 in the following cycle.
- R10: While `rst` is high at a clock edge, all outputs become zero.
- R11: Outputs reflect the word issued at the previous rising clock edge (one cycle latency).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| issue_vld | input | 1 | An instruction is issued this cycle |
| instr | input | 32 | Instruction word |
| rs_val | input | XLEN | Source operand value |
| rb_val | input | XLEN | Shift operand value |
| xer_so | input | 1 | Current summary-overflow bit |
| gpr_we | output | 1 | Write the result to the destination register |
| dst_idx | output | 5 | Destination register index |
| result | output | XLEN | Zero-extended rotate-and-mask result |
| cr_we | output | 1 | Write `cr0` to condition field 0 |
| cr0 | output | 4 | Condition value {LT, GT, EQ, SO} |

## Verification
The hardest situation to reach from the ports is a wrapping mask combined with a rotate amount that differs between the two shift sources, since a wrong source selection or a missed wrap can still yield a plausible word. The stimulus table pairs wrapping and non-wrapping begin/end values with shift operands whose upper bits are all set and with immediates that disagree with `rb_val[4:0]`, and a bench model built from a bit-by-bit rotate and a modular walk from begin to end supplies every expected value. Directed cases add single-bit masks, zero results, and source upper halves full of ones.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned AMT_W  = $clog2(WORD_W);
  localparam int unsigned REG_W  = 5;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned CR_W   = 4;

  localparam logic [OPC_W-1:0] OPC_ROT_IMM = 6'd21;
  localparam logic [OPC_W-1:0] OPC_ROT_REG = 6'd23;

  // Layout matches the instruction word, first member at the MSB.
  typedef struct packed {
    logic [OPC_W-1:0] opc;
    logic [REG_W-1:0] src;
    logic [REG_W-1:0] dst;
    logic [AMT_W-1:0] amt;
    logic [AMT_W-1:0] mb;
    logic [AMT_W-1:0] me;
    logic             rc;
  } mform_t;

  typedef enum logic [1:0] {
    AMT_NONE = 2'd0,
    AMT_IMM  = 2'd1,
    AMT_REG  = 2'd2
  } amt_src_e;
endpackage

// File: rtl/rotmask_decode.sv
module rotmask_decode
  import rotmask_pkg::*;
(
  input  logic [WORD_W-1:0] instr,
  input  logic [AMT_W-1:0]  rb_amt,
  output mform_t            fields,
  output logic [AMT_W-1:0]  amt,
  output logic              legal
);
  amt_src_e src_sel;
  logic     unused_src;

  assign fields     = mform_t'(instr);
  assign unused_src = ^fields.src;

  always_comb begin
    unique case (fields.opc)
      OPC_ROT_IMM: src_sel = AMT_IMM;
      OPC_ROT_REG: src_sel = AMT_REG;
      default:     src_sel = AMT_NONE;
    endcase
  end

  always_comb begin
    case (src_sel)
      AMT_IMM: amt = fields.amt;
      AMT_REG: amt = rb_amt;
      default: amt = '0;
    endcase
  end

  assign legal = (src_sel != AMT_NONE);
endmodule

// File: rtl/rotmask_rotator.sv
module rotmask_rotator #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  output logic [W-1:0]  dout
);
  logic [2*W-1:0] doubled;
  logic [2*W-1:0] shifted;
  logic           unused_low;

  assign doubled    = {din, din};
  assign shifted    = doubled << amt;
  assign dout       = shifted[2*W-1:W];
  assign unused_low = ^shifted[W-1:0];
endmodule

// File: rtl/rotmask_mask_gen.sv
module rotmask_mask_gen #(
  parameter int unsigned W = 32,
  localparam int unsigned SW = $clog2(W)
) (
  input  logic [SW-1:0] mb,
  input  logic [SW-1:0] me,
  output logic [W-1:0]  mask
);
  logic wraps;
  assign wraps = (mb > me);

  // Position p uses MSB-first numbering: p = 0 drives mask[W-1].
  for (genvar p = 0; p < W; p++) begin : g_bit
    localparam logic [SW-1:0] POS = SW'(p);
    logic from_begin;
    logic to_end;
    assign from_begin = (POS >= mb);
    assign to_end     = (POS <= me);
    assign mask[W-1-p] = wraps ? (from_begin | to_end) : (from_begin & to_end);
  end
endmodule

// File: rtl/rotmask_cr_calc.sv
module rotmask_cr_calc
  import rotmask_pkg::*;
(
  input  logic [WORD_W-1:0] res,
  input  logic              so_in,
  output logic [CR_W-1:0]   cr
);
  logic neg;
  logic zero;

  assign neg  = res[WORD_W-1];
  assign zero = (res == '0);
  assign cr   = {neg, ~neg & ~zero, zero, so_in};
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit
  import rotmask_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                issue_vld,
  input  logic [WORD_W-1:0]   instr,
  input  logic [XLEN-1:0]     rs_val,
  input  logic [XLEN-1:0]     rb_val,
  input  logic                xer_so,
  output logic                gpr_we,
  output logic [REG_W-1:0]    dst_idx,
  output logic [XLEN-1:0]     result,
  output logic                cr_we,
  output logic [CR_W-1:0]     cr0
);
  localparam int unsigned PAD_W = XLEN - WORD_W;

  mform_t              fields;
  logic [AMT_W-1:0]    amt;
  logic                legal;
  logic [WORD_W-1:0]   rotated;
  logic [WORD_W-1:0]   mask;
  logic [WORD_W-1:0]   masked;
  logic [CR_W-1:0]     cr_next;
  logic                unused_hi;

  assign unused_hi = ^{rs_val[XLEN-1:WORD_W], rb_val[XLEN-1:AMT_W]};

  rotmask_decode u_dec (
    .instr  (instr),
    .rb_amt (rb_val[AMT_W-1:0]),
    .fields (fields),
    .amt    (amt),
    .legal  (legal)
  );

  rotmask_rotator #(.W(WORD_W)) u_rot (
    .din  (rs_val[WORD_W-1:0]),
    .amt  (amt),
    .dout (rotated)
  );

  rotmask_mask_gen #(.W(WORD_W)) u_mask (
    .mb   (fields.mb),
    .me   (fields.me),
    .mask (mask)
  );

  assign masked = rotated & mask;

  rotmask_cr_calc u_cr (
    .res   (masked),
    .so_in (xer_so),
    .cr    (cr_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      gpr_we  <= 1'b0;
      cr_we   <= 1'b0;
      dst_idx <= '0;
      result  <= '0;
      cr0     <= '0;
    end else begin
      gpr_we  <= issue_vld & legal;
      cr_we   <= issue_vld & legal & fields.rc;
      dst_idx <= fields.dst;
      result  <= {{PAD_W{1'b0}}, masked};
      cr0     <= cr_next;
    end
  end
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk
  import rotmask_pkg::*;
#(
  parameter int unsigned XLEN = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              issue_vld,
  input logic [WORD_W-1:0] instr,
  input logic              xer_so,
  input logic              gpr_we,
  input logic [XLEN-1:0]   result,
  input logic              cr_we,
  input logic [CR_W-1:0]   cr0
);
  // R6
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    gpr_we |-> (result[XLEN-1:WORD_W] == '0));

  // R7
  cr_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> ($countones(cr0[3:1]) == 1));

  // R7
  cr_eq_match_chk: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> (cr0[1] == (result[WORD_W-1:0] == '0)));

  // R7
  cr_so_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && instr[0]) |=> (!cr_we || (cr0[0] == $past(xer_so))));

  // R8
  no_record_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_vld && !instr[0]) |=> !cr_we);

  // R9
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!issue_vld || (instr[31:26] != OPC_ROT_IMM && instr[31:26] != OPC_ROT_REG))
      |=> (!gpr_we && !cr_we));

  // R8
  cr_implies_gpr_chk: assert property (@(posedge clk) disable iff (rst)
    cr_we |-> gpr_we);
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) chk_i (.*);

// File: tb/rotmask_unit_tb_top.sv
module rotmask_unit_tb_top;
  localparam int XLEN = 64;
  localparam int NV   = 10;
  localparam int WATCHDOG_CYC = 5000;

  logic            clk = 1'b0;
  logic            rst;
  logic            issue_vld;
  logic [31:0]     instr;
  logic [XLEN-1:0] rs_val, rb_val;
  logic            xer_so;
  logic            gpr_we, cr_we;
  logic [4:0]      dst_idx;
  logic [XLEN-1:0] result;
  logic [3:0]      cr0;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rotmask_unit #(.XLEN(XLEN)) dut_i (
    .clk(clk), .rst(rst), .issue_vld(issue_vld), .instr(instr),
    .rs_val(rs_val), .rb_val(rb_val), .xer_so(xer_so),
    .gpr_we(gpr_we), .dst_idx(dst_idx), .result(result),
    .cr_we(cr_we), .cr0(cr0)
  );

  // Stimulus table: {opc, dst, sh, mb, me, rc}, source, shift operand, so
  localparam logic [26:0] VF [NV] = '{
    {6'd23, 5'd3,  5'd0,  5'd0,  5'd31, 1'b1},
    {6'd23, 5'd7,  5'd9,  5'd4,  5'd27, 1'b0},
    {6'd23, 5'd31, 5'd0,  5'd24, 5'd7,  1'b1},
    {6'd21, 5'd1,  5'd13, 5'd0,  5'd15, 1'b1},
    {6'd21, 5'd12, 5'd31, 5'd30, 5'd1,  1'b1},
    {6'd21, 5'd0,  5'd5,  5'd17, 5'd17, 1'b0},
    {6'd23, 5'd20, 5'd2,  5'd31, 5'd0,  1'b1},
    {6'd21, 5'd9,  5'd0,  5'd16, 5'd15, 1'b1},
    {6'd24, 5'd4,  5'd3,  5'd0,  5'd31, 1'b1},
    {6'd23, 5'd6,  5'd1,  5'd8,  5'd8,  1'b1}
  };
  localparam logic [63:0] VRS [NV] = '{
    64'h0000_0000_1234_5678, 64'hFFFF_FFFF_89AB_CDEF, 64'h0123_4567_F00D_BEEF,
    64'h0000_0000_8000_0001, 64'hAAAA_AAAA_5555_AAAA, 64'h0000_0000_FFFF_FFFF,
    64'hFFFF_0000_C000_0003, 64'h0000_0000_0000_0000, 64'h0000_0000_1111_1111,
    64'h0000_0000_0080_0000
  };
  localparam logic [63:0] VRB [NV] = '{
    64'hFFFF_FFFF_FFFF_FFE8, 64'h0000_0000_0000_0011, 64'h8000_0000_0000_001F,
    64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_001C,
    64'h7FFF_FFFF_FFFF_FFE0, 64'h0000_0000_0000_0007, 64'h0000_0000_0000_0002,
    64'h0000_0000_0000_0021
  };
  localparam logic VSO [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};

  function automatic logic [31:0] mk(input logic [26:0] f);
    return {f[26:21], 5'd17, f[20:0]};
  endfunction

  // Reference built bit by bit: rotate by index arithmetic, mask by a modular walk.
  function automatic logic [31:0] ref_res(input logic [31:0] w, input logic [63:0] rs,
                                          input logic [63:0] rb);
    int sh;
    int pos;
    logic [31:0] rot;
    logic [31:0] msk;
    sh  = (w[31:26] == 6'd23) ? int'(rb[4:0]) : int'(w[15:11]);
    rot = '0;
    for (int k = 0; k < 32; k++) rot[(k + sh) % 32] = rs[k];
    msk = '0;
    pos = int'(w[10:6]);
    for (int step = 0; step < 32; step++) begin
      msk[31 - pos] = 1'b1;
      if (pos == int'(w[5:1])) break;
      pos = (pos + 1) % 32;
    end
    return rot & msk;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, let one rising edge pass, sample at the next falling edge.
  task automatic issue(input logic v, input logic [31:0] w, input logic [63:0] rs,
                       input logic [63:0] rb, input logic so);
    issue_vld = v; instr = w; rs_val = rs; rb_val = rb; xer_so = so;
    @(negedge clk);
    issue_vld = 1'b0;
  endtask

  task automatic check_full(input string tag, input logic [31:0] w, input logic [63:0] rs,
                            input logic [63:0] rb, input logic so);
    logic [31:0] r;
    logic        legal;
    logic [3:0]  c;
    r     = ref_res(w, rs, rb);
    legal = (w[31:26] == 6'd21) || (w[31:26] == 6'd23);
    c     = {r[31], !r[31] && (r != 0), r == 0, so};
    issue(1'b1, w, rs, rb, so);
    chk({tag, " R9 gpr_we"}, 64'(gpr_we), 64'(legal));
    chk({tag, " R8 cr_we"}, 64'(cr_we), 64'(legal & w[0]));
    if (legal) begin
      chk({tag, " R1 dst_idx"}, 64'(dst_idx), 64'(w[20:16]));
      chk({tag, " R11 result"}, result, {32'd0, r});
      if (w[0]) chk({tag, " R7 cr0"}, 64'(cr0), 64'(c));
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; issue_vld = 1'b0; instr = '0; rs_val = '0; rb_val = '0; xer_so = 1'b0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10 gpr_we", 64'(gpr_we), 64'd0);
    chk("R10 cr_we",  64'(cr_we),  64'd0);
    chk("R10 result", result, 64'd0);
    chk("R10 cr0",    64'(cr0), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++)
      check_full("table", mk(VF[i]), VRS[i], VRB[i], VSO[i]);

    // R2: register form, upper shift bits set, rotate by 8
    issue(1'b1, mk({6'd23, 5'd2, 5'd0, 5'd0, 5'd31, 1'b0}), 64'h1234_5678, 64'hFFFF_FFFF_FFFF_FFE8, 1'b0);
    chk("R2 rb low bits only", result, 64'h0000_0000_3456_7812);
    // R3: immediate form, shift operand differs, same result for two values
    issue(1'b1, mk({6'd21, 5'd2, 5'd4, 5'd28, 5'd3, 1'b0}), 64'hF000_000F, 64'd9, 1'b0);
    chk("R3 imm amt rb=9", result, 64'h0000_0000_0000_000F);
    issue(1'b1, mk({6'd21, 5'd2, 5'd4, 5'd28, 5'd3, 1'b0}), 64'hF000_000F, 64'd0, 1'b0);
    chk("R3 imm amt rb=0", result, 64'h0000_0000_0000_000F);
    // R5: wrapping mask on all-ones source
    issue(1'b1, mk({6'd21, 5'd2, 5'd0, 5'd28, 5'd3, 1'b0}), 64'hFFFF_FFFF, 64'd0, 1'b0);
    chk("R5 wrap mask", result, 64'h0000_0000_F000_000F);
    // R4: single-bit mask at position 0, LT with SO
    issue(1'b1, mk({6'd21, 5'd2, 5'd0, 5'd0, 5'd0, 1'b1}), 64'hFFFF_FFFF, 64'd0, 1'b1);
    chk("R4 single bit", result, 64'h0000_0000_8000_0000);
    chk("R7 LT+SO", 64'(cr0), 64'b1001);
    // R6: upper source half ignored, GT
    issue(1'b1, mk({6'd21, 5'd2, 5'd0, 5'd0, 5'd31, 1'b1}), 64'hDEAD_BEEF_0000_0001, 64'd0, 1'b0);
    chk("R6 upper zero", result, 64'h0000_0000_0000_0001);
    chk("R7 GT", 64'(cr0), 64'b0100);
    // R7: zero result gives EQ
    issue(1'b1, mk({6'd23, 5'd2, 5'd0, 5'd4, 5'd7, 1'b1}), 64'hF0FF_FFFF, 64'd0, 1'b1);
    chk("R7 EQ zero", result, 64'd0);
    chk("R7 EQ cr0", 64'(cr0), 64'b0011);
    // R9: no issue gives no writes
    issue(1'b0, mk({6'd23, 5'd2, 5'd0, 5'd0, 5'd31, 1'b1}), 64'h1, 64'd0, 1'b0);
    chk("R9 idle gpr_we", 64'(gpr_we), 64'd0);
    chk("R9 idle cr_we", 64'(cr_we), 64'd0);
    // R10: reset after activity clears outputs
    issue(1'b1, mk({6'd21, 5'd2, 5'd0, 5'd0, 5'd31, 1'b1}), 64'h5, 64'd0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk("R10 mid reset gpr_we", 64'(gpr_we), 64'd0);
    chk("R10 mid reset result", result, 64'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule